// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Interface

This block sits between a processor bus and a serial line engine. Software polls or takes an interrupt, then uses two word offsets. One offset carries data: a read returns the most recent received byte and a write hands a byte to the transmitter. The other offset reports status flags. Which data register is meant depends only on whether the access is a read or a write.

On the line side, the block takes each received byte on a one-cycle strobe. It keeps that byte until a newer one replaces it. It offers each outgoing byte to a serialiser through a valid/busy handshake. The bit framing and the baud timing live in the serialiser and are not part of this block.

An interrupt request follows the receive-ready flag, gated by an enable input. This lets software choose between polling and interrupt-driven reception.

Top module: `serial_regif`

## Requirements
- R1: A read at offset 0x10 returns the held received byte in bits 7:0 with all upper bits zero. A read at offset 0x14 returns status with receive-ready in bit 0, transmit-ready in bit 1, overrun in bit 2, and zeros above. A read at any other offset, and `bus_rdata` whenever no read is in progress, is zero.
- R2: A cycle with `rx_valid` high stores `rx_byte` as the held byte, and receive-ready is 1 from the next cycle.
- R3: A read at offset 0x10 clears receive-ready from the next cycle, unless `rx_valid` is high in that same cycle.
- R4: A byte arriving while receive-ready is 1 and the data offset is not being read in that cycle replaces the held byte and sets the sticky overrun flag.
- R5: A read at offset 0x14 clears the overrun flag. If a new overrun occurs in the same cycle, the flag stays set.
- R6: A write at offset 0x10 while transmit-ready is 1 latches bits 7:0 of the write data onto `tx_byte`. From the next cycle, transmit-ready is 0 and `tx_valid` is 1. `tx_valid` stays 1 until the cycle in which `tx_busy` is sampled high.
- R7: A write at offset 0x10 while transmit-ready is 0 is dropped: `tx_byte` and `tx_valid` do not change.
- R8: After `tx_busy` has been seen high, transmit-ready returns to 1 on the cycle after `tx_busy` is sampled low.
- R9: `irq` is 1 exactly when receive-ready is 1 and `irq_en` is 1.
- R10: After reset, status reads 0x2, the held byte reads 0, `tx_valid` is 0 and `irq` is 0.
- R11: Writes to offset 0x14 or to any unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the read |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | BYTE_W (8) | Received byte |
| tx_valid | output | 1 | A byte is offered to the serialiser |
| tx_byte | output | BYTE_W (8) | Byte to send |
| tx_busy | input | 1 | Serialiser is sending a byte |
| irq_en | input | 1 | Enables the receive interrupt |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench aims at several same-cycle collisions:
- A data read that coincides with a new receive strobe. A design that lets the clear win would lose the new byte's ready flag.
- A status read that coincides with a fresh overrun. A clear-wins design would hide the overrun.
- A data read at the moment a byte lands on a full holder. Flagging this as an overrun would wrongly report a lost byte.

It also writes the data offset while the serialiser is still busy. A design that accepted that write would corrupt the byte on the line. Stores to the status and unmapped offsets are checked to confirm they leave every flag alone. A long pseudo-random stretch mixes all of these with variable serialiser lengths, so that ordering slips show up.

// File: rtl/serial_regif_pkg.sv
// Package: shared types and status bit positions for the serial
// register interface. Assumes a status word of at least 3 bits.
package serial_regif_pkg;

    // Transmit handshake state.
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_LAUNCH = 2'd1,
        TX_SEND   = 2'd2
    } tx_state_e;

    // Status bit positions: software polls these.
    localparam int ST_RX_RDY = 0;
    localparam int ST_TX_RDY = 1;
    localparam int ST_OVRUN  = 2;

endpackage

// File: rtl/srif_bus_decode.sv
// srif_bus_decode: turns one bus access into the data-read, status-read
// and data-write strobes. Assumes a full-width address compare; an
// unmatched offset produces no strobe.
module srif_bus_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h10,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              data_rd,
    output logic              stat_rd,
    output logic              data_wr
);

    logic hit_data;
    logic hit_stat;

    // Offset match and direction split.
    always_comb begin
        hit_data = (bus_addr == DATA_OFS);
        hit_stat = (bus_addr == STAT_OFS);
        data_rd  = bus_sel && !bus_we && hit_data;
        stat_rd  = bus_sel && !bus_we && hit_stat;
        data_wr  = bus_sel &&  bus_we && hit_data;
    end

endmodule

// File: rtl/srif_rx_hold.sv
// srif_rx_hold: holds the last received byte with its ready flag and a
// sticky overrun flag. Assumes rx_valid is a single-cycle strobe per
// byte. A new byte always wins over a same-cycle clear.
module srif_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              data_rd,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] held,
    output logic              rdy,
    output logic              ovr
);

    logic lost;

    // A byte is lost only if the holder is full and not being read now.
    always_comb lost = rx_valid && rdy && !data_rd;

    // Capture the byte on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= '0;
        else if (rx_valid) held <= rx_byte;
    end

    // Ready flag: set by arrival, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdy <= 1'b0;
        else if (rx_valid) rdy <= 1'b1;
        else if (data_rd)  rdy <= 1'b0;
    end

    // Overrun flag: set on loss, cleared by a status read; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (lost)    ovr <= 1'b1;
        else if (stat_rd) ovr <= 1'b0;
    end

endmodule

// File: rtl/srif_tx_launch.sv
// srif_tx_launch: accepts one byte from the bus and offers it to the
// serialiser. Assumes the serialiser raises tx_busy in response to
// tx_valid and lowers it when the byte is sent.
module srif_tx_launch
    import serial_regif_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              tx_busy,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_ready
);

    tx_state_e state;

    // Handshake sequencing: idle -> offer -> sending -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            case (state)
                TX_IDLE:   if (data_wr) state <= TX_LAUNCH;
                TX_LAUNCH: if (tx_busy) state <= TX_SEND;
                TX_SEND:   if (!tx_busy) state <= TX_IDLE;
                default:   state <= TX_IDLE;
            endcase
        end
    end

    // Byte latch: loads only when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tx_byte <= '0;
        else if (data_wr && state == TX_IDLE) tx_byte <= wr_byte;
    end

    // Handshake outputs decoded from state.
    always_comb begin
        tx_valid = (state == TX_LAUNCH);
        tx_ready = (state == TX_IDLE);
    end

endmodule

// File: rtl/serial_regif.sv
// serial_regif: processor-side registers of a serial port. One offset
// is receive data on reads and transmit data on writes; a second is
// status. Assumes single-cycle bus accesses with read data returned in
// the same cycle.
module serial_regif
    import serial_regif_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h10,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_busy,
    input  logic              irq_en,
    output logic              irq
);

    localparam int PAD_W = DATA_W - BYTE_W;

    logic              data_rd;
    logic              stat_rd;
    logic              data_wr;
    logic [BYTE_W-1:0] held;
    logic              rx_rdy;
    logic              ovr;
    logic              tx_ready;
    logic [DATA_W-1:0] data_word;
    logic [DATA_W-1:0] stat_word;

    srif_bus_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_OFS(DATA_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .data_rd (data_rd),
        .stat_rd (stat_rd),
        .data_wr (data_wr)
    );

    srif_rx_hold #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .data_rd (data_rd),
        .stat_rd (stat_rd),
        .held    (held),
        .rdy     (rx_rdy),
        .ovr     (ovr)
    );

    srif_tx_launch #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .wr_byte (bus_wdata[BYTE_W-1:0]),
        .tx_busy (tx_busy),
        .tx_valid(tx_valid),
        .tx_byte (tx_byte),
        .tx_ready(tx_ready)
    );

    // Zero-extend the held byte into a full data word.
    generate
        if (PAD_W > 0) begin : g_pad
            assign data_word = {{PAD_W{1'b0}}, held};
        end else begin : g_nopad
            assign data_word = held[DATA_W-1:0];
        end
    endgenerate

    // Assemble the status word from the flags.
    always_comb begin
        stat_word            = '0;
        stat_word[ST_RX_RDY] = rx_rdy;
        stat_word[ST_TX_RDY] = tx_ready;
        stat_word[ST_OVRUN]  = ovr;
    end

    // Read return mux: zero unless a mapped read is in progress.
    always_comb begin
        if (data_rd)      bus_rdata = data_word;
        else if (stat_rd) bus_rdata = stat_word;
        else              bus_rdata = '0;
    end

    // Interrupt request follows receive-ready under the enable.
    always_comb irq = rx_rdy && irq_en;

endmodule

// File: rtl/srif_checker.sv
// srif_checker: temporal properties of serial_regif, attached by bind.
// Observes ports plus the internal ready and overrun flags.
module srif_checker #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS = 'h10,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_busy,
    input logic              irq_en,
    input logic              irq,
    input logic              rx_rdy,
    input logic              ovr,
    input logic              tx_ready
);

    logic c_drd;
    logic c_srd;
    logic c_dwr;

    // Independent view of the access kind.
    always_comb begin
        c_drd = bus_sel && !bus_we && (bus_addr == DATA_OFS);
        c_srd = bus_sel && !bus_we && (bus_addr == STAT_OFS);
        c_dwr = bus_sel &&  bus_we && (bus_addr == DATA_OFS);
    end

    p_rdata_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_drd |-> (bus_rdata[DATA_W-1:BYTE_W] == '0));

    p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_rdy);

    p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_drd && !rx_valid) |=> !rx_rdy);

    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rdy && !c_drd) |=> ovr);

    p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_srd && !(rx_valid && rx_rdy)) |=> !ovr);

    p_tx_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dwr && tx_ready) |=>
            (tx_valid && !tx_ready && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

    p_tx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dwr && !tx_ready) |=> $stable(tx_byte));

    p_tx_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !tx_valid && !tx_busy) |=> tx_ready);

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (irq == irq_en));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind serial_regif srif_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BYTE_W  (BYTE_W),
    .DATA_OFS(DATA_OFS),
    .STAT_OFS(STAT_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .tx_busy  (tx_busy),
    .irq_en   (irq_en),
    .irq      (irq),
    .rx_rdy   (rx_rdy),
    .ovr      (ovr),
    .tx_ready (tx_ready)
);

// File: tb/sim_serial_regif.sv
// sim_serial_regif: behavioural reference model compared on every clock.
module sim_serial_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_busy = 1'b0;
    logic        irq_en = 1'b0;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    int    ser_len = 4;
    int    ser_cnt = 0;
    bit    active = 1'b0;
    string cur_req = "R10";

    // Reference state
    int m_rdy = 0, m_ovr = 0, m_held = 0, m_st = 0, m_txb = 0;

    always #2 clk = ~clk;  // 250 MHz

    serial_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_busy(tx_busy), .irq_en(irq_en), .irq(irq)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference model update at each edge.
    always @(posedge clk) begin
        bit rd_d, rd_s, wr_d;
        cycles++;
        rd_d = bus_sel && !bus_we && bus_addr == 8'h10;
        rd_s = bus_sel && !bus_we && bus_addr == 8'h14;
        wr_d = bus_sel &&  bus_we && bus_addr == 8'h10;
        if (!rst_n) begin
            m_rdy = 0; m_ovr = 0; m_held = 0; m_st = 0; m_txb = 0;
        end else begin
            if (rx_valid && m_rdy == 1 && !rd_d) m_ovr = 1;
            else if (rd_s) m_ovr = 0;
            if (rx_valid) begin m_rdy = 1; m_held = rx_byte; end
            else if (rd_d) m_rdy = 0;
            case (m_st)
                0: if (wr_d) begin m_st = 1; m_txb = bus_wdata[7:0]; end
                1: if (tx_busy) m_st = 2;
                default: if (!tx_busy) m_st = 0;
            endcase
        end
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL [watchdog] run hung: act=%0d cycles exp<=20000", cycles);
            finish_run();
        end
    end

    // Serialiser emulation: answers tx_valid with a busy window.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            tx_busy = 1'b0; ser_cnt = 0;
        end else if (ser_cnt > 0) begin
            ser_cnt--;
            if (ser_cnt == 0) tx_busy = 1'b0;
        end else if (tx_valid && !tx_busy) begin
            tx_busy = 1'b1; ser_cnt = ser_len;
        end
    end

    // Compare outputs mid-cycle.
    always @(negedge clk) begin
        logic [31:0] e_rd;
        bit e_tv, e_irq;
        if (active) begin
            e_rd = '0;
            if (bus_sel && !bus_we && bus_addr == 8'h10) e_rd = m_held;
            else if (bus_sel && !bus_we && bus_addr == 8'h14)
                e_rd = {29'd0, m_ovr[0], (m_st == 0), m_rdy[0]};
            e_tv  = (m_st == 1);
            e_irq = (m_rdy == 1) && irq_en;
            n_cmp++;
            if (bus_rdata !== e_rd || tx_valid !== e_tv ||
                tx_byte !== m_txb[7:0] || irq !== e_irq) begin
                n_bad++;
                $display("FAIL [%s] t=%0t act rd=%h tv=%b tb=%h irq=%b exp rd=%h tv=%b tb=%h irq=%b",
                         cur_req, $time, bus_rdata, tx_valid, tx_byte, irq,
                         e_rd, e_tv, m_txb[7:0], e_irq);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_bus();
        bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; rx_valid = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_sel = 1; bus_we = 0; bus_addr = a; tick(); idle_bus();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; tick(); idle_bus();
    endtask

    task automatic rx(input logic [7:0] b);
        rx_valid = 1; rx_byte = b; tick(); idle_bus();
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) tick();
        rst_n = 1; active = 1;
        // R10: reset state
        cur_req = "R10"; irq_en = 1;
        rd(8'h14); rd(8'h10); tick();
        // R2: capture and ready
        cur_req = "R2"; rx(8'hA5); rd(8'h14); tick();
        // R9: interrupt gating
        cur_req = "R9"; irq_en = 0; tick(); irq_en = 1; tick();
        // R3: data read clears ready
        cur_req = "R3"; rd(8'h10); rd(8'h14);
        // R1: padding and unmapped read
        cur_req = "R1"; rd(8'h20); rd(8'h11);
        // R4: overwrite with overrun
        cur_req = "R4"; rx(8'h11); rx(8'h22); rd(8'h14); rd(8'h10);
        // R5: status read clears, set wins on collision
        cur_req = "R5"; rd(8'h14); rx(8'h33);
        bus_sel = 1; bus_addr = 8'h14; rx_valid = 1; rx_byte = 8'h44; tick(); idle_bus();
        rd(8'h14); rd(8'h14);
        // R3: same-cycle read and arrival keeps ready, no overrun
        cur_req = "R3";
        bus_sel = 1; bus_addr = 8'h10; rx_valid = 1; rx_byte = 8'h55; tick(); idle_bus();
        rd(8'h14); rd(8'h10); rd(8'h14);
        // R6: write starts a transfer
        cur_req = "R6"; ser_len = 5;
        wr(8'h10, 32'h1234_56C3); tick();
        // R7: write while busy is dropped
        cur_req = "R7"; wr(8'h10, 32'h0000_0077); rd(8'h14);
        // R8: ready returns after busy drops
        cur_req = "R8"; repeat (8) tick(); rd(8'h14);
        wr(8'h10, 32'hFFFF_FF0E); repeat (8) tick();
        // R11: writes elsewhere ignored
        cur_req = "R11"; rx(8'h66);
        wr(8'h14, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); rd(8'h14); rd(8'h10);
        // Mixed pseudo-random stretch
        lf = 32'h1BAD_5EED;
        for (int i = 0; i < 600; i++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            ser_len = 1 + (lf[30:28] % 6);
            irq_en = lf[12] | lf[13];
            rx_valid = lf[8] & lf[9]; rx_byte = lf[23:16];
            case (lf[2:0])
                3'd0: begin cur_req = "R3"; bus_sel = 1; bus_we = 0; bus_addr = 8'h10; end
                3'd1: begin cur_req = "R5"; bus_sel = 1; bus_we = 0; bus_addr = 8'h14; end
                3'd2: begin cur_req = "R7"; bus_sel = 1; bus_we = 1; bus_addr = 8'h10; bus_wdata = lf; end
                3'd3: begin cur_req = "R11"; bus_sel = 1; bus_we = 1; bus_addr = 8'h14; bus_wdata = lf; end
                3'd4: begin cur_req = "R1"; bus_sel = 1; bus_we = 0; bus_addr = 8'h20; end
                default: begin cur_req = "R2"; bus_sel = 0; end
            endcase
            tick(); idle_bus();
        end
        repeat (12) tick();
        finish_run();
    end

endmodule